// File: doc/BRIEF.md
# Vectored Countdown Timer Interrupt Source

This block is the timer of a local interrupt controller. Software sets it up with a few register writes: a 32-bit control word, a 32-bit start value and a 3-bit prescale select. The control word holds the interrupt vector, the delivery mode, the trigger style, a mask bit and a repeat bit. A nonzero start value loads a down-counter. The counter then loses one every 2^d clocks, where d is the prescale select.

When the count runs out, the block looks at the mask bit. If the mask bit is clear, it sends out a one-cycle request. The request carries the vector, the delivery mode and the trigger style that are held in the control word at that moment. The repeat bit is then checked whether or not the entry is masked. If it is set, the counter reloads from the start value and keeps going. If it is clear, the counter stops at zero. A registered read port returns the stored settings and the live count.

Top module: `irq_timer`

## Requirements
- R1: After reset, `irq_pulse` is 0, the live count is 0 and the control word reads back as 0x0001_0000 (masked).
- R2: Of a control-word write (select 0), only bits 10:0, 13, 15, 16 and 17 are kept. Every other bit reads back as 0.
- R3: A nonzero write to select 1 loads that value into the count at the write edge. The count then drops by exactly one every 2^d clocks, where d is the value stored from bits 2:0 of a select-3 write.
- R4: When the count reaches zero with mask bit 16 clear, `irq_pulse` is high for exactly one cycle. That cycle is the first cycle in which the count is 0.
- R5: During the pulse, `irq_vector` equals control bits 7:0, `irq_mode` equals bits 10:8 and `irq_level` equals bit 15.
- R6: With mask bit 16 set, expiry raises no pulse, but the repeat decision still applies.
- R7: With repeat bit 17 set, the count reloads the start value one cycle after it reaches zero, so the period is N·2^d+1 clocks. With bit 17 clear, the count stays at 0 and no further pulse follows.
- R8: Writing 0 to select 1 stops the timer. The count reads 0 from then on and no pulse is raised.
- R9: `rd_data` presents, one cycle after `rd_sel`, the control word (0), the start value (1), the live count (2) or the prescale select (3).
- R10: A new select-1 write while counting restarts the countdown from the new value. The old countdown raises no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 start value, 2 none, 3 prescale |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read target: 0 control, 1 start value, 2 live count, 3 prescale |
| rd_data | output | 32 | Registered read data |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector of the request |
| irq_mode | output | 3 | Delivery mode of the request |
| irq_level | output | 1 | Trigger style of the request (1 level, 0 edge) |

## Verification
Time is counted in falling edges after the write edge that loads a start value N. The live count then sits one cycle behind on `rd_data`: at falling edge m it shows N−floor((m−1)/2^d). The pulse is due at exactly m = N·2^d. In repeat mode it recurs every N·2^d+1 edges. The bench records the edge index of every pulse inside a fixed window and compares the list with these formulas, so both a late pulse and an extra pulse are caught. Masked, stopped and restarted runs are checked the same way: over the window the pulse must stay low, and the reloaded or frozen count is read at a known edge.

// File: rtl/irq_timer_pkg.sv
package irq_timer_pkg;
  localparam int ENTRY_W  = 32;
  localparam int VEC_LSB  = 0;
  localparam int MODE_LSB = 8;
  localparam int TRIG_BIT = 15;
  localparam int MASK_BIT = 16;
  localparam int REP_BIT  = 17;
  // writable control bits: vector, mode, polarity, trigger, mask, repeat
  localparam logic [ENTRY_W-1:0] ENTRY_WMASK = 32'h0003_A7FF;
  localparam logic [ENTRY_W-1:0] ENTRY_RST   = 32'h0001_0000;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_START = 2'd1,
    SEL_LIVE  = 2'd2,
    SEL_PRE   = 2'd3
  } sel_e;
endpackage

// File: rtl/irq_timer_regs.sv
module irq_timer_regs
  import irq_timer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int DIV_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [31:0]        wr_data,
  output logic [ENTRY_W-1:0] entry_q,
  output logic [CNT_W-1:0]   start_q,
  output logic [DIV_W-1:0]   div_q,
  output logic               load,
  output logic [CNT_W-1:0]   load_val
);
  sel_e sel;
  assign sel      = sel_e'(wr_sel);
  assign load     = wr_en && (sel == SEL_START);
  assign load_val = wr_data[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      entry_q <= ENTRY_RST;
      start_q <= '0;
      div_q   <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_CTRL:  entry_q <= wr_data & ENTRY_WMASK;
        SEL_START: start_q <= load_val;
        SEL_PRE:   div_q   <= wr_data[DIV_W-1:0];
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/irq_timer_prescale.sv
module irq_timer_prescale #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int PRE_W = (1 << DIV_W) - 1;

  logic [PRE_W-1:0] pcnt;
  logic [PRE_W-1:0] pmask;

  assign pmask = (PRE_W'(1) << div) - PRE_W'(1);
  assign tick  = (pcnt & pmask) == pmask;

  always_ff @(posedge clk) begin
    if (rst || clr || !run) pcnt <= '0;
    else                    pcnt <= pcnt + PRE_W'(1);
  end
endmodule

// File: rtl/irq_timer_count.sv
module irq_timer_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] start_val,
  input  logic             repeat_en,
  input  logic             tick,
  output logic [CNT_W-1:0] count_q,
  output logic             run_q,
  output logic             exp_q,
  output logic             expire_now
);
  logic step;
  assign step       = run_q && !exp_q && tick && !load;
  assign expire_now = step && (count_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      run_q   <= 1'b0;
      exp_q   <= 1'b0;
    end else if (load) begin
      count_q <= load_val;
      run_q   <= (load_val != '0);
      exp_q   <= 1'b0;
    end else if (exp_q) begin
      exp_q <= 1'b0;
      if (repeat_en && (start_val != '0)) count_q <= start_val;
      else                                run_q   <= 1'b0;
    end else if (expire_now) begin
      count_q <= '0;
      exp_q   <= 1'b1;
    end else if (step) begin
      count_q <= count_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/irq_timer_issue.sv
module irq_timer_issue #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             expire_now,
  input  logic             masked,
  input  logic [VEC_W-1:0] vec_in,
  input  logic [2:0]       mode_in,
  input  logic             level_in,
  output logic             irq_pulse,
  output logic [VEC_W-1:0] irq_vector,
  output logic [2:0]       irq_mode,
  output logic             irq_level
);
  logic fire;
  assign fire = expire_now && !masked;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_pulse  <= 1'b0;
      irq_vector <= '0;
      irq_mode   <= '0;
      irq_level  <= 1'b0;
    end else begin
      irq_pulse <= fire;
      if (fire) begin
        irq_vector <= vec_in;
        irq_mode   <= mode_in;
        irq_level  <= level_in;
      end
    end
  end
endmodule

// File: rtl/irq_timer.sv
module irq_timer
  import irq_timer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int DIV_W = 3,
  parameter int VEC_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [31:0]       wr_data,
  input  logic [1:0]        rd_sel,
  output logic [31:0]       rd_data,
  output logic              irq_pulse,
  output logic [VEC_W-1:0]  irq_vector,
  output logic [2:0]        irq_mode,
  output logic              irq_level
);
  logic [ENTRY_W-1:0] entry_q;
  logic [CNT_W-1:0]   start_q;
  logic [DIV_W-1:0]   div_q;
  logic               load;
  logic [CNT_W-1:0]   load_val;
  logic               tick;
  logic [CNT_W-1:0]   cnt_val;
  logic               running;
  logic               expired;
  logic               expire_now;

  irq_timer_regs #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .entry_q(entry_q), .start_q(start_q), .div_q(div_q),
    .load(load), .load_val(load_val)
  );

  irq_timer_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst(rst), .clr(load || expired), .run(running),
    .div(div_q), .tick(tick)
  );

  irq_timer_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load(load), .load_val(load_val),
    .start_val(start_q), .repeat_en(entry_q[REP_BIT]), .tick(tick),
    .count_q(cnt_val), .run_q(running), .exp_q(expired),
    .expire_now(expire_now)
  );

  irq_timer_issue #(.VEC_W(VEC_W)) u_issue (
    .clk(clk), .rst(rst), .expire_now(expire_now),
    .masked(entry_q[MASK_BIT]),
    .vec_in(entry_q[VEC_LSB +: VEC_W]),
    .mode_in(entry_q[MODE_LSB +: 3]),
    .level_in(entry_q[TRIG_BIT]),
    .irq_pulse(irq_pulse), .irq_vector(irq_vector),
    .irq_mode(irq_mode), .irq_level(irq_level)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (sel_e'(rd_sel))
        SEL_CTRL:  rd_data <= entry_q;
        SEL_START: rd_data <= 32'(start_q);
        SEL_LIVE:  rd_data <= 32'(cnt_val);
        default:   rd_data <= 32'(div_q);
      endcase
    end
  end
endmodule

// File: rtl/irq_timer_chk.sv
module irq_timer_chk
  import irq_timer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic [1:0]         wr_sel,
  input logic [ENTRY_W-1:0] entry_q,
  input logic [CNT_W-1:0]   cnt_val,
  input logic               running,
  input logic               irq_pulse,
  input logic [VEC_W-1:0]   irq_vector,
  input logic [2:0]         irq_mode,
  input logic               irq_level
);
  logic start_wr;
  assign start_wr = wr_en && (wr_sel == 2'd1);

  // R4
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |=> !irq_pulse);

  // R4
  pulse_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> (cnt_val == '0));

  // R6
  pulse_unmasked_chk: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> !$past(entry_q[MASK_BIT]));

  // R5
  pulse_fields_chk: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> (irq_vector == $past(entry_q[VEC_LSB +: VEC_W]) &&
                   irq_mode == $past(entry_q[MODE_LSB +: 3]) &&
                   irq_level == $past(entry_q[TRIG_BIT])));

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_val != '0 && !start_wr) |=>
      (cnt_val == $past(cnt_val) || cnt_val == $past(cnt_val) - CNT_W'(1)));

  // R8
  stopped_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!running && !start_wr) |=> (cnt_val == '0 && !irq_pulse));
endmodule

bind irq_timer irq_timer_chk #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
  .entry_q(entry_q), .cnt_val(cnt_val), .running(running),
  .irq_pulse(irq_pulse), .irq_vector(irq_vector),
  .irq_mode(irq_mode), .irq_level(irq_level)
);

// File: tb/irq_timer_tb_top.sv
module irq_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = 2'd0;
  logic [31:0] rd_data;
  logic        irq_pulse;
  logic [7:0]  irq_vector;
  logic [2:0]  irq_mode;
  logic        irq_level;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  irq_timer dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .irq_pulse(irq_pulse),
    .irq_vector(irq_vector), .irq_mode(irq_mode), .irq_level(irq_level)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // called at a falling edge; the write takes effect at the next rising edge
  task automatic reg_write(input logic [1:0] sel, input logic [31:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] sel, output logic [31:0] val);
    rd_sel = sel;
    @(negedge clk);
    val = rd_data;
  endtask

  task automatic test_reset();
    logic [31:0] v;
    check("R1 pulse", {31'd0, irq_pulse}, 32'd0);
    reg_read(2'd0, v); check("R1 control", v, 32'h0001_0000);
    reg_read(2'd2, v); check("R1 count", v, 32'd0);
  endtask

  task automatic test_ctrl_bits();
    logic [31:0] v;
    reg_write(2'd0, 32'hFFFF_FFFF);
    reg_read(2'd0, v); check("R2 kept bits", v, 32'h0003_A7FF);
  endtask

  task automatic test_read_port();
    logic [31:0] v;
    reg_write(2'd3, 32'h0000_00FD);
    reg_read(2'd3, v); check("R9 prescale", v, 32'd5);
    reg_write(2'd1, 32'd0);
    reg_read(2'd1, v); check("R9 start", v, 32'd0);
    reg_write(2'd3, 32'd0);
  endtask

  task automatic test_oneshot();
    int first = -1;
    int np = 0;
    logic [7:0] vec = 8'h00;
    logic [2:0] md = 3'd0;
    logic lv = 1'b0;
    reg_write(2'd3, 32'd0);
    reg_write(2'd0, 32'h0000_8241);
    rd_sel = 2'd2;
    reg_write(2'd1, 32'd5);
    for (int m = 1; m <= 20; m++) begin
      @(negedge clk);
      if (m == 3) check("R3 count d=0", rd_data, 32'd3);
      if (irq_pulse) begin
        np++;
        if (first < 0) begin first = m; vec = irq_vector; md = irq_mode; lv = irq_level; end
      end
    end
    check("R4 pulse edge", first, 32'd5);
    check("R7 one-shot pulses", np, 32'd1);
    check("R5 vector", {24'd0, vec}, 32'h41);
    check("R5 mode", {29'd0, md}, 32'd2);
    check("R5 level", {31'd0, lv}, 32'd1);
    check("R7 one-shot count", rd_data, 32'd0);
  endtask

  task automatic test_periodic();
    int pt[3] = '{-1, -1, -1};
    int np = 0;
    reg_write(2'd3, 32'd2);
    reg_write(2'd0, 32'h0002_0022);
    rd_sel = 2'd2;
    reg_write(2'd1, 32'd3);
    for (int m = 1; m <= 40; m++) begin
      @(negedge clk);
      if (m == 5) check("R3 count d=2", rd_data, 32'd2);
      if (irq_pulse) begin
        if (np < 3) pt[np] = m;
        np++;
        check("R5 edge level", {31'd0, irq_level}, 32'd0);
      end
    end
    check("R7 pulses", np, 32'd3);
    check("R7 first", pt[0], 32'd12);
    check("R7 second", pt[1], 32'd25);
    check("R7 third", pt[2], 32'd38);
    // stop
    np = 0;
    reg_write(2'd1, 32'd0);
    for (int m = 1; m <= 30; m++) begin
      @(negedge clk);
      if (irq_pulse) np++;
    end
    check("R8 no pulse", np, 32'd0);
    check("R8 count", rd_data, 32'd0);
  endtask

  task automatic test_masked();
    int np = 0;
    reg_write(2'd3, 32'd0);
    reg_write(2'd0, 32'h0003_0011);
    rd_sel = 2'd2;
    reg_write(2'd1, 32'd4);
    for (int m = 1; m <= 20; m++) begin
      @(negedge clk);
      if (m == 5) check("R6 zero seen", rd_data, 32'd0);
      if (m == 6) check("R6 reload while masked", rd_data, 32'd4);
      if (irq_pulse) np++;
    end
    check("R6 no pulse", np, 32'd0);
    reg_write(2'd1, 32'd0);
  endtask

  task automatic test_restart();
    int first = -1;
    int np = 0;
    reg_write(2'd3, 32'd0);
    reg_write(2'd0, 32'h0000_0077);
    rd_sel = 2'd2;
    reg_write(2'd1, 32'd10);
    repeat (3) begin
      @(negedge clk);
      if (irq_pulse) np++;
    end
    reg_write(2'd1, 32'd4);
    for (int m = 1; m <= 20; m++) begin
      @(negedge clk);
      if (irq_pulse) begin np++; if (first < 0) first = m; end
    end
    check("R10 restart edge", first, 32'd4);
    check("R10 single pulse", np, 32'd1);
    check("R10 vector", {24'd0, irq_vector}, 32'h77);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_ctrl_bits();
    test_read_port();
    test_oneshot();
    test_periodic();
    test_masked();
    test_restart();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule